// File: doc/BRIEF.md
# Watermark Boost Frequency Governor

This block keeps a boost frequency for one channel of an activity monitor and re-tunes it each time the monitor hands over a sample. A sample carries the averaged activity count and two status flags. One flag reports that the count stayed above the upper watermark for several consecutive periods. The other reports the same for the lower watermark. An upper flag makes the boost grow by a percentage of itself plus a fixed step, and the boost stops at the maximum frequency. A lower flag makes the boost shrink by a percentage, and the boost drops straight to zero once it falls under half a step.

With each sample the block also decides which of the two consecutive-watermark interrupt directions stay armed. It recomputes the pair of average watermarks around the new count. One cycle later it produces a target frequency: the sampled count per sampling period, scaled up by the sustain factor derived from the upper threshold, plus the boost. A one-cycle done pulse marks the cycle in which the target is valid. Coefficients, the threshold, the dependency threshold and the maximum frequency are inputs, so one instance can serve any channel's configuration.

Top module: `boost_governor`

## Requirements
- R1: On a sample with the upper flag set, the boost becomes boost*up_coeff/100 + 16000, using truncating division. If that value is greater than or equal to max_freq, the boost becomes max_freq instead. The new boost is visible on the cycle after the sampling edge.
- R2: After a sample with the upper flag set, arm_below is 1. arm_above is 1 if the boost did not reach max_freq, and 0 if it was clamped.
- R3: On a sample with only the lower flag set, the boost becomes boost*down_coeff/100. If that value is below 8000, the boost becomes 0. A value of exactly 8000 is kept.
- R4: After a sample with only the lower flag set, arm_above is 1. arm_below is 1 if the boost is nonzero, and 0 if it snapped to zero.
- R5: When both flags are set on a sample, the upper rule applies and the lower flag has no effect.
- R6: When dep_thresh is nonzero, this rule overrides R2 and R4 for arm_below. If avg_count >= dep_thresh, arm_below is 1. Otherwise, if the new boost is 0, arm_below is 0. On a sample with neither flag set, boost and arm_above keep their values and arm_below is subject only to this rule.
- R7: Two edges after a sampling edge, target = (avg/12)*(10000/up_thresh)/100 + boost, with every division truncating and boost taken as its new value. The target saturates at all ones, and an up_thresh of 0 gives a scale of 0. done is 1 for exactly that cycle.
- R8: On the cycle after a sample, let band = (max_freq*6/1000)*12. wm_hi becomes avg+band, saturated at all ones. wm_lo becomes avg-band, or 0 when avg < band.
- R9: While reset is low, boost, target, wm_hi, wm_lo and done are 0, and arm_above and arm_below are 1.
- R10: While sample_valid is 0, the flags and data inputs are ignored. The boost and both arm bits hold their values, and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Strobe: a monitor sample is present |
| evt_upper | input | 1 | Consecutive-upper status flag of the sample |
| evt_lower | input | 1 | Consecutive-lower status flag of the sample |
| avg_count | input | CW | Sampled average activity count |
| max_freq | input | FW | Maximum frequency, upper limit of the boost |
| up_coeff | input | KW | Growth percentage |
| down_coeff | input | KW | Decay percentage |
| up_thresh | input | KW | Upper threshold percentage, sets the sustain factor |
| dep_thresh | input | CW | Dependency threshold; 0 disables R6 |
| boost | output | FW | Current boost frequency |
| arm_above | output | 1 | Re-arm enable for the consecutive-upper interrupt |
| arm_below | output | 1 | Re-arm enable for the consecutive-lower interrupt |
| wm_hi | output | CW | Upper average watermark |
| wm_lo | output | CW | Lower average watermark |
| target | output | FW | Target frequency |
| done | output | 1 | Target valid pulse |

## Verification
The bench uses the default parameters: 32-bit frequency and count paths, 10-bit coefficients, a step of 16000, a period of 12 and a band of 6 per mille. The 10-bit coefficients hold the 800 percent growth factor. Halving 16000 with a 50 percent decay lands exactly on the 8000 boundary, and a 90 percent decay chain crosses it from above. The 32-bit count lets a value near the top of its range push the upper watermark into saturation. Both coefficient sets are exercised, including a maximum frequency that is small enough for the second upper event to clamp.

// File: rtl/boost_governor.sv
module boost_governor #(
  parameter int FW      = 32,
  parameter int CW      = 32,
  parameter int KW      = 10,
  parameter int STEP    = 16000,
  parameter int PERIOD  = 12,
  parameter int BAND_PM = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_valid,
  input  logic          evt_upper,
  input  logic          evt_lower,
  input  logic [CW-1:0] avg_count,
  input  logic [FW-1:0] max_freq,
  input  logic [KW-1:0] up_coeff,
  input  logic [KW-1:0] down_coeff,
  input  logic [KW-1:0] up_thresh,
  input  logic [CW-1:0] dep_thresh,
  output logic [FW-1:0] boost,
  output logic          arm_above,
  output logic          arm_below,
  output logic [CW-1:0] wm_hi,
  output logic [CW-1:0] wm_lo,
  output logic [FW-1:0] target,
  output logic          done
);

  localparam int XW = ((FW > CW) ? FW : CW) + KW + 16;
  localparam logic [XW-1:0] STEP_X = XW'(STEP);
  localparam logic [XW-1:0] HALF_X = XW'(STEP / 2);
  localparam logic [XW-1:0] PCT    = XW'(100);
  localparam logic [XW-1:0] MILLE  = XW'(1000);
  localparam logic [XW-1:0] PER_X  = XW'(PERIOD);
  localparam logic [XW-1:0] BAND_X = XW'(BAND_PM);
  localparam logic [XW-1:0] SUSTN  = XW'(10000);
  localparam logic [XW-1:0] FMAX   = XW'({FW{1'b1}});
  localparam logic [XW-1:0] CMAX   = XW'({CW{1'b1}});

  logic [XW-1:0] boost_x, grown, decayed, band, hi_full, sustain, t_full;
  logic [FW-1:0] boost_nxt;
  logic          above_nxt, below_raw, below_nxt;
  logic [CW-1:0] avg_q;
  logic          v1;

  assign boost_x = XW'(boost);
  assign grown   = boost_x * XW'(up_coeff) / PCT + STEP_X;
  assign decayed = boost_x * XW'(down_coeff) / PCT;

  always_comb begin
    boost_nxt = boost;
    above_nxt = arm_above;
    below_raw = arm_below;
    if (evt_upper) begin
      below_raw = 1'b1;
      if (grown >= XW'(max_freq)) begin
        boost_nxt = max_freq;
        above_nxt = 1'b0;
      end else begin
        boost_nxt = grown[FW-1:0];
        above_nxt = 1'b1;
      end
    end else if (evt_lower) begin
      above_nxt = 1'b1;
      if (decayed < HALF_X) begin
        boost_nxt = '0;
        below_raw = 1'b0;
      end else begin
        boost_nxt = decayed[FW-1:0];
        below_raw = 1'b1;
      end
    end
    below_nxt = below_raw;
    if (dep_thresh != '0) begin
      if (avg_count >= dep_thresh) below_nxt = 1'b1;
      else if (boost_nxt == '0)    below_nxt = 1'b0;
    end
  end

  assign band    = (XW'(max_freq) * BAND_X / MILLE) * PER_X;
  assign hi_full = XW'(avg_count) + band;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boost     <= '0;
      arm_above <= 1'b1;
      arm_below <= 1'b1;
      wm_hi     <= '0;
      wm_lo     <= '0;
      avg_q     <= '0;
      v1        <= 1'b0;
    end else begin
      v1 <= sample_valid;
      if (sample_valid) begin
        boost     <= boost_nxt;
        arm_above <= above_nxt;
        arm_below <= below_nxt;
        avg_q     <= avg_count;
        wm_hi     <= (hi_full > CMAX) ? '1 : hi_full[CW-1:0];
        wm_lo     <= (XW'(avg_count) >= band) ? avg_count - band[CW-1:0] : '0;
      end
    end
  end

  assign sustain = (up_thresh == '0) ? '0 : SUSTN / XW'(up_thresh);
  assign t_full  = (XW'(avg_q) / PER_X) * sustain / PCT + boost_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target <= '0;
      done   <= 1'b0;
    end else begin
      done <= v1;
      if (v1) target <= (t_full > FMAX) ? '1 : t_full[FW-1:0];
    end
  end

  a_r1_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && evt_upper |=> boost <= $past(max_freq));

  a_r2_below_armed: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && evt_upper && dep_thresh == '0 |=> arm_below);

  a_r3_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !evt_upper && evt_lower && down_coeff <= KW'(100) |=> boost <= $past(boost));

  a_r4_above_armed: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !evt_upper && evt_lower |=> arm_above);

  a_r6_dep_force: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && dep_thresh != '0 && avg_count >= dep_thresh |=> arm_below);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> ##1 done);

  a_r8_wm_order: assert property (@(posedge clk) disable iff (!rst_n)
    wm_lo <= wm_hi);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(boost) && $stable(arm_above) && $stable(arm_below));

endmodule

// File: tb/boost_governor_bench.sv
`timescale 1ns/1ps
module boost_governor_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0, evt_upper = 1'b0, evt_lower = 1'b0;
  logic [31:0] avg_count = '0, max_freq = '0, dep_thresh = '0;
  logic [9:0]  up_coeff = '0, down_coeff = '0, up_thresh = '0;
  logic [31:0] boost, wm_hi, wm_lo, target;
  logic        arm_above, arm_below, done;

  int checks = 0;
  int failures = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  boost_governor u_boost_governor (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .evt_upper(evt_upper), .evt_lower(evt_lower), .avg_count(avg_count),
    .max_freq(max_freq), .up_coeff(up_coeff), .down_coeff(down_coeff),
    .up_thresh(up_thresh), .dep_thresh(dep_thresh), .boost(boost),
    .arm_above(arm_above), .arm_below(arm_below), .wm_hi(wm_hi),
    .wm_lo(wm_lo), .target(target), .done(done)
  );

  typedef struct packed {
    logic        up;
    logic        dn;
    logic        cfg;
    logic [31:0] avg;
    logic [31:0] maxf;
    logic [31:0] exp_boost;
    logic        exp_above;
    logic        exp_below;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 32'd6000,   32'd800000, 32'd16000,  1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 32'd6000,   32'd800000, 32'd48000,  1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 32'd6000,   32'd800000, 32'd112000, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 32'd6000,   32'd800000, 32'd240000, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 32'd6000,   32'd800000, 32'd496000, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 32'd6000,   32'd800000, 32'd800000, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b0, 32'd6000,   32'd800000, 32'd800000, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b0, 32'd100000, 32'd800000, 32'd400000, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 32'd100000, 32'd800000, 32'd200000, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 32'd100000, 32'd800000, 32'd100000, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 32'd100000, 32'd800000, 32'd50000,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 32'd100000, 32'd800000, 32'd25000,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 32'd100000, 32'd800000, 32'd12500,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 32'd100000, 32'd800000, 32'd0,      1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 32'd30000,  32'd800000, 32'd0,      1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 32'd30000,  32'd800000, 32'd16000,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 32'd30000,  32'd800000, 32'd8000,   1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 32'd30000,  32'd800000, 32'd0,      1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 32'd60000,  32'd800000, 32'd0,      1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b1, 32'd1000,   32'd800000, 32'd0,      1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b1, 32'd1000,   32'd800000, 32'd16000,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 32'd1000,   32'd800000, 32'd14400,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 32'd1000,   32'd800000, 32'd12960,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 32'd1000,   32'd800000, 32'd11664,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 32'd1000,   32'd800000, 32'd10497,  1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 32'd1000,   32'd800000, 32'd9447,   1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 32'd1000,   32'd800000, 32'd8502,   1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 32'd1000,   32'd800000, 32'd0,      1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 32'd70000,  32'd800000, 32'd0,      1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 32'd70000,  32'd20000,  32'd16000,  1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 32'd70000,  32'd20000,  32'd20000,  1'b0, 1'b1}
  };

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned ref_target(longint unsigned avg, longint unsigned upth,
                                                 longint unsigned b);
    longint unsigned s, t;
    s = (upth == 0) ? 0 : 10000 / upth;
    t = (avg / 12) * s / 100 + b;
    return (t > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : t;
  endfunction

  function automatic longint unsigned ref_band(longint unsigned m);
    return (m * 6 / 1000) * 12;
  endfunction

  task automatic set_cfg(input logic c);
    if (!c) begin up_coeff = 10'd200; down_coeff = 10'd50; up_thresh = 10'd60; dep_thresh = 32'd0; end
    else    begin up_coeff = 10'd800; down_coeff = 10'd90; up_thresh = 10'd27; dep_thresh = 32'd50000; end
  endtask

  task automatic run_sample(input logic up, input logic dn, input logic [31:0] avg,
                            input logic [31:0] maxf, input logic [31:0] eb, input logic ea,
                            input logic ebl, input int idx);
    longint unsigned band, hi, lo;
    @(negedge clk);
    evt_upper = up; evt_lower = dn; avg_count = avg; max_freq = maxf; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0; evt_upper = 1'b0; evt_lower = 1'b0;
    band = ref_band(maxf);
    hi = avg + band;
    if (hi > 64'hFFFF_FFFF) hi = 64'hFFFF_FFFF;
    lo = (avg >= band) ? avg - band : 0;
    chk($sformatf("R1 R3 R5 boost vec%0d", idx), boost, eb);
    chk($sformatf("R2 R4 R6 arm_above vec%0d", idx), arm_above, ea);
    chk($sformatf("R2 R4 R6 arm_below vec%0d", idx), arm_below, ebl);
    chk($sformatf("R8 wm_hi vec%0d", idx), wm_hi, hi);
    chk($sformatf("R8 wm_lo vec%0d", idx), wm_lo, lo);
    @(negedge clk);
    chk($sformatf("R7 target vec%0d", idx), target, ref_target(avg, up_thresh, eb));
    chk($sformatf("R7 done vec%0d", idx), done, 1);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
    $finish;
  end

  initial begin
    logic [31:0] held;
    set_cfg(1'b0);
    repeat (3) @(negedge clk);
    chk("R9 reset boost", boost, 0);
    chk("R9 reset target", target, 0);
    chk("R9 reset arm_above", arm_above, 1);
    chk("R9 reset arm_below", arm_below, 1);
    chk("R9 reset done", done, 0);
    chk("R9 reset wm_hi", wm_hi, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i].cfg);
      run_sample(VEC[i].up, VEC[i].dn, VEC[i].avg, VEC[i].maxf,
                 VEC[i].exp_boost, VEC[i].exp_above, VEC[i].exp_below, i);
    end

    // R10: flags and data ignored without sample_valid
    held = boost;
    @(negedge clk);
    evt_upper = 1'b1; evt_lower = 1'b1; max_freq = 32'd0; avg_count = 32'd999999;
    repeat (5) @(negedge clk);
    chk("R10 boost held", boost, held);
    chk("R10 arm_above held", arm_above, 0);
    chk("R10 arm_below held", arm_below, 1);
    chk("R10 done idle", done, 0);
    evt_upper = 1'b0; evt_lower = 1'b0;

    // R8 upper watermark saturation, no event keeps boost (R6 with dep 0)
    set_cfg(1'b0);
    run_sample(1'b0, 1'b0, 32'hFFFF_FFF0, 32'd800000, held, 1'b0, 1'b1, 100);

    // R9 reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 re-reset boost", boost, 0);
    chk("R9 re-reset arm_above", arm_above, 1);
    rst_n = 1'b1;

    // R1 growth from zero with coefficient set B after reset
    set_cfg(1'b1);
    run_sample(1'b1, 1'b0, 32'd70000, 32'd800000, 32'd16000, 1'b1, 1'b1, 200);
    run_sample(1'b1, 1'b0, 32'd70000, 32'd800000, 32'd144000, 1'b1, 1'b1, 201);

    repeat (2) @(negedge clk);
    report();
    $finish;
  end

endmodule